// File: doc/BRIEF.md
# Serial Register-Bank Slave with Ones-Run Reset

This block is the serial slave side of a small configuration interface. A host drives a serial clock, an active-low select and a data line. The block oversamples all three with the system clock, decodes a one-byte command, and then moves 8 or 16 data bits into or out of one of eight register slots. The data phase is as long as the width of the addressed slot.

Input bits are taken on rising serial clock edges. Output bits change on falling edges. The serial clock idles high. Frames can be bounded by the select line, or the select line can stay low for good. In that case frames are delimited only by bit counting.

A run of at least `RUN_LIM` consecutive ones on the data line, counted over rising edges while select is low, has two effects. It puts the frame logic back to waiting for a command, and it returns every register to its power-on value. After that, the block ignores the serial pins for `HOLD_CYC` system clocks and raises `busy`.

The serial lines carry their own framing, so they have no valid/ready handshake. All pins are plain levels.

Top module: `spireg_slave`

## Requirements
- R1: A frame opens with a command byte sent MSB first. Bit 7 must be 0, bit 6 selects read (1) or write (0), bits 5:3 carry the slot address, and bits 2:0 must be 0. If bit 7 or any of bits 2:0 is 1, the frame still runs its data phase, but it writes nothing and `spi_miso_oe` stays low.
- R2: In a read, the MSB of the slot is put on `spi_miso` at the first falling edge after the eighth command bit. One further bit follows on each falling edge, and `spi_miso_oe` is high throughout the read data phase.
- R3: Slot map, as width / access / power-on value:
  - 0: 8 / RW / 0x00
  - 1: 16 / RO / 0xC3A5
  - 2: 8 / RO / 0x5A
  - 3: 16 / RW / 0x4E20
  - 4: 16 / RW / 0x0500
  - 5: 8 / RW / 0x05
  - 6 and 7: 8 / reserved / read 0x00
- R4: A write commits only when the full 8 or 16 data bits have been received. If select rises earlier, the slot is left unchanged.
- R5: Writes to read-only or reserved slots change nothing.
- R6: After the ones-run reset, every slot reads back its power-on value, and the next bit starts a new command byte.
- R7: After the ones-run reset, `busy` is high for exactly `HOLD_CYC` system clocks. During that time serial edges are ignored, and writes in particular have no effect.
- R8: With select held low, frames follow each other back to back, delimited by bit count alone.
- R9: `spi_miso_oe` is low, and `spi_miso` is 0, while select is high, outside a read data phase, and while `busy` is high.
- R10: The ones counter saturates at `RUN_LIM`, so a continuing run triggers only once. Any 0 bit restarts the count, so 31 ones followed by a 0 trigger nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idles high |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 when not enabled |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| busy | output | 1 | High during the hold-off after a ones-run reset |

## Verification
A bit counter that is off by one shifts every later frame, which matters most with select tied low. That fault shows up in the very next read as a value rotated by one position, or as `spi_miso_oe` rising one bit early or late. A write latched from the wrong state shows up only on a later read of that slot, so each write is followed by a read-back through the scoreboard. A ones counter that fails to clear or to saturate shows up at the ports as `busy` rising where it should not, or as a hold-off whose length differs from `HOLD_CYC`.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int NREG  = 8;
  localparam int AW    = 3;
  localparam int DW    = 16;
  localparam int CMD_BITS = 8;

  localparam logic [DW-1:0] ID_WORD  = 16'hC3A5;
  localparam logic [DW-1:0] REV_BYTE = 16'h005A;

  typedef enum logic [0:0] {ST_CMD = 1'b0, ST_DATA = 1'b1} frame_st_t;

  typedef struct packed {
    logic          wide;
    logic          writable;
    logic [DW-1:0] por;
  } slot_attr_t;

  function automatic slot_attr_t slot_attr(input logic [AW-1:0] a);
    slot_attr_t r;
    case (a)
      3'd0:    r = '{wide: 1'b0, writable: 1'b1, por: 16'h0000};
      3'd1:    r = '{wide: 1'b1, writable: 1'b0, por: ID_WORD};
      3'd2:    r = '{wide: 1'b0, writable: 1'b0, por: REV_BYTE};
      3'd3:    r = '{wide: 1'b1, writable: 1'b1, por: 16'h4E20};
      3'd4:    r = '{wide: 1'b1, writable: 1'b1, por: 16'h0500};
      3'd5:    r = '{wide: 1'b0, writable: 1'b1, por: 16'h0005};
      default: r = '{wide: 1'b0, writable: 1'b0, por: 16'h0000};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spireg_runmon.sv
module spireg_runmon #(
  parameter int RUN_LIM = 32,
  localparam int CW = $clog2(RUN_LIM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_stb,
  input  logic          bit_val,
  output logic [CW-1:0] run_cnt,
  output logic          ser_rst
);
  assign ser_rst = bit_stb && bit_val && (run_cnt == CW'(RUN_LIM - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else if (bit_stb) begin
      if (!bit_val)                      run_cnt <= '0;
      else if (run_cnt != CW'(RUN_LIM))  run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spireg_frame.sv
module spireg_frame
  import spireg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fall,
  input  logic          cs_act,
  input  logic          mosi,
  input  logic          hold,
  input  logic          ser_rst,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          miso_q,
  output logic          miso_oe
);
  localparam int CNTW = $clog2(DW);

  frame_st_t      state;
  logic [DW-2:0]  sh_in;
  logic [DW-1:0]  out_sh;
  logic [CNTW-1:0] cnt;
  logic           rw_q, ok_q, wide_q;
  logic [AW-1:0]  addr_q;
  logic [7:0]     cmd_byte;
  logic           cmd_ok;
  logic           cmd_wide;
  logic [DW-1:0]  load_val;
  logic [CNTW-1:0] last_idx;

  assign cmd_byte = {sh_in[6:0], mosi};
  assign cmd_ok   = !cmd_byte[7] && (cmd_byte[2:0] == 3'b000);
  assign rd_addr  = cmd_byte[5:3];
  assign cmd_wide = slot_attr(rd_addr).wide;
  assign load_val = cmd_wide ? rd_data : {rd_data[7:0], 8'h00};
  assign last_idx = wide_q ? CNTW'(DW - 1) : CNTW'(7);
  assign miso_oe  = (state == ST_DATA) && rw_q && ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_CMD;
      sh_in   <= '0;
      out_sh  <= '0;
      cnt     <= '0;
      rw_q    <= 1'b0;
      ok_q    <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      miso_q  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (ser_rst || hold || !cs_act) begin
        state  <= ST_CMD;
        cnt    <= '0;
        miso_q <= 1'b0;
      end else if (rise) begin
        sh_in <= {sh_in[DW-3:0], mosi};
        if (state == ST_CMD) begin
          if (cnt == CNTW'(CMD_BITS - 1)) begin
            state  <= ST_DATA;
            cnt    <= '0;
            rw_q   <= cmd_byte[6];
            ok_q   <= cmd_ok;
            addr_q <= rd_addr;
            wide_q <= cmd_wide;
            out_sh <= load_val;
            miso_q <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (cnt == last_idx) begin
          state   <= ST_CMD;
          cnt     <= '0;
          wr_en   <= !rw_q && ok_q;
          wr_addr <= addr_q;
          wr_data <= {sh_in, mosi};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (fall && miso_oe) begin
        miso_q <= out_sh[DW-1];
        out_sh <= {out_sh[DW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spireg_bank.sv
module spireg_bank
  import spireg_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [DW-1:0]           rd_data,
  output logic [NREG-1:0][DW-1:0] slots
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam slot_attr_t A = slot_attr(AW'(g));
    localparam logic [DW-1:0] MASK = A.wide ? {DW{1'b1}} : DW'(8'hFF);
    logic [DW-1:0] r;
    if (A.writable) begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 r <= A.por;
        else if (ser_rst)                           r <= A.por;
        else if (wr_en && (wr_addr == AW'(g)))      r <= wr_data & MASK;
      end
    end else begin : g_ro
      assign r = A.por;
    end
    assign slots[g] = r;
  end

  assign rd_data = slots[rd_addr];
endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
  import spireg_pkg::*;
#(
  parameter int HOLD_CYC = 50000,
  parameter int RUN_LIM = 32,
  parameter int SYNC_STAGES = 2,
  localparam int HW = $clog2(HOLD_CYC + 1),
  localparam int CW = $clog2(RUN_LIM + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe,
  output logic busy
);
  logic sclk_s, cs_n_s, mosi_s, sclk_d;
  logic rise, fall, cs_act;
  logic ser_rst;
  logic [CW-1:0] run_cnt;
  logic [HW-1:0] hold_cnt;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en, miso_q;
  logic [NREG-1:0][DW-1:0] slots;

  spireg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk, spi_cs_n, spi_mosi}),
    .q({sclk_s, cs_n_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b1;
    else        sclk_d <= sclk_s;
  end

  assign rise   = sclk_s && !sclk_d;
  assign fall   = !sclk_s && sclk_d;
  assign cs_act = !cs_n_s;
  assign busy   = (hold_cnt != '0);

  spireg_runmon #(.RUN_LIM(RUN_LIM)) u_run (
    .clk(clk), .rst_n(rst_n),
    .bit_stb(rise && cs_act && !busy),
    .bit_val(mosi_s),
    .run_cnt(run_cnt),
    .ser_rst(ser_rst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_cnt <= '0;
    else if (ser_rst)  hold_cnt <= HW'(HOLD_CYC);
    else if (busy)     hold_cnt <= hold_cnt - 1'b1;
  end

  spireg_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .rise(rise), .fall(fall), .cs_act(cs_act), .mosi(mosi_s),
    .hold(busy), .ser_rst(ser_rst),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .miso_q(miso_q), .miso_oe(spi_miso_oe)
  );

  spireg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .ser_rst(ser_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .slots(slots)
  );

  assign spi_miso = spi_miso_oe && miso_q;
endmodule

// File: rtl/spireg_chk.sv
module spireg_chk
  import spireg_pkg::*;
#(
  parameter int RUN_LIM = 32,
  localparam int CW = $clog2(RUN_LIM + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ser_rst,
  input logic                    busy,
  input logic                    cs_act,
  input logic                    miso_oe,
  input logic                    wr_en,
  input logic [AW-1:0]           wr_addr,
  input logic [CW-1:0]           run_cnt,
  input logic [NREG-1:0][DW-1:0] slots
);
  logic [NREG-1:0][DW-1:0] por_all;
  always_comb begin
    for (int i = 0; i < NREG; i++) por_all[i] = slot_attr(AW'(i)).por;
  end

  assert_busy_after_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_rst |=> busy);
  assert_no_write_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_en);
  assert_por_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_rst |=> (slots == por_all));
  assert_quiet_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !miso_oe);
  assert_quiet_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso_oe);
  assert_run_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CW'(RUN_LIM));
  assert_ro_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !slot_attr(wr_addr).writable) |=> $stable(slots));
endmodule

bind spireg_slave spireg_chk #(.RUN_LIM(RUN_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_rst(ser_rst), .busy(busy),
  .cs_act(cs_act), .miso_oe(spi_miso_oe), .wr_en(wr_en),
  .wr_addr(wr_addr), .run_cnt(run_cnt), .slots(slots)
);

// File: tb/sim_spireg_slave.sv
module sim_spireg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int HOLD = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, busy;

  int n_chk = 0, n_fail = 0;
  logic [15:0] model [8];
  logic [15:0] exp_v[$], act_v[$];
  string exp_tag[$];
  int bcur = 0, blast = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spireg_slave #(.HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe), .busy(busy)
  );

  function automatic int w_of(input int a);
    return (a == 1 || a == 3 || a == 4) ? 16 : 8;
  endfunction
  function automatic bit wr_ok(input int a);
    return (a == 0 || a == 3 || a == 4 || a == 5);
  endfunction
  function automatic logic [15:0] por_of(input int a);
    case (a)
      1: return 16'hC3A5; 2: return 16'h005A; 3: return 16'h4E20;
      4: return 16'h0500; 5: return 16'h0005; default: return 16'h0000;
    endcase
  endfunction

  task automatic clk_n(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (act_v.size() > 0 && exp_v.size() > 0) begin
      automatic logic [15:0] a = act_v.pop_front();
      automatic logic [15:0] e = exp_v.pop_front();
      automatic string t = exp_tag.pop_front();
      check(t, a, e);
    end
  end

  always @(negedge clk) begin
    if (busy) bcur++;
    else if (bcur != 0) begin blast = bcur; bcur = 0; end
  end

  task automatic bit_out(input logic b, output logic got, output logic oe);
    sclk = 1'b0; mosi = b;
    clk_n(HALF);
    got = miso; oe = miso_oe;
    sclk = 1'b1;
    clk_n(HALF);
  endtask

  task automatic frame(input logic [7:0] cmd, input int w, input logic [15:0] wd,
                       input int stop_after, output logic [15:0] rd,
                       output logic oe_all, output logic oe_any);
    logic g, o;
    rd = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 0; i < 8; i++) bit_out(cmd[7-i], g, o);
    for (int k = 0; k < w; k++) begin
      if (k == stop_after) break;
      bit_out(wd[w-1-k], g, o);
      rd = {rd[14:0], g};
      oe_all &= o; oe_any |= o;
    end
  endtask

  task automatic cs_lo; cs_n = 1'b0; clk_n(4); endtask
  task automatic cs_hi; clk_n(4); cs_n = 1'b1; clk_n(6); endtask

  task automatic wr(input int a, input logic [15:0] v, input bit tied);
    logic [15:0] r; logic oa, on;
    if (!tied) cs_lo;
    frame({1'b0, 1'b0, 3'(a), 3'b000}, w_of(a), v, 99, r, oa, on);
    if (!tied) cs_hi;
    if (wr_ok(a)) model[a] = (w_of(a) == 8) ? {8'h00, v[7:0]} : v;
  endtask

  task automatic rd(input int a, input string tag, input bit tied);
    logic [15:0] r; logic oa, on;
    exp_v.push_back(model[a]); exp_tag.push_back(tag);
    if (!tied) cs_lo;
    frame({1'b0, 1'b1, 3'(a), 3'b000}, w_of(a), 16'h0000, 99, r, oa, on);
    if (!tied) cs_hi;
    act_v.push_back(r);
    check({tag, " R2 enable during read"}, {15'd0, oa}, 16'd1);
  endtask

  task automatic ones(input int n);
    logic g, o;
    for (int i = 0; i < n; i++) bit_out(1'b1, g, o);
  endtask

  task automatic wait_idle;
    int t = 0;
    while (busy && t < 10000) begin clk_n(1); t++; end
    clk_n(4);
  endtask

  initial begin
    clk_n(200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r; logic oa, on, g, o;
    for (int i = 0; i < 8; i++) model[i] = por_of(i);
    clk_n(5); rst_n = 1'b1; clk_n(5);
    check("R9 reset oe", {15'd0, miso_oe}, 16'd0);
    check("R9 reset miso", {15'd0, miso}, 16'd0);
    check("R7 reset busy", {15'd0, busy}, 16'd0);

    for (int a = 0; a < 8; a++) rd(a, "R3 por map", 0);

    wr(0, 16'h00A7, 0); rd(0, "R4 rw8", 0);
    wr(3, 16'h1234, 0); rd(3, "R4 rw16", 0);
    wr(5, 16'h003C, 0); rd(5, "R3 rw8", 0);
    wr(1, 16'hFFFF, 0); rd(1, "R5 ro16", 0);
    wr(2, 16'h0000, 0); rd(2, "R5 ro8", 0);
    wr(6, 16'h00FF, 0); rd(6, "R5 reserved", 0);

    // R1: reserved low bits set -> write dropped, read not driven
    cs_lo; frame(8'h01, 8, 16'h0011, 99, r, oa, on); cs_hi;
    rd(0, "R1 bad cmd write", 0);
    cs_lo; frame(8'h44, 8, 16'h0000, 99, r, oa, on); cs_hi;
    check("R1 bad cmd read oe", {15'd0, on}, 16'd0);
    cs_lo; frame(8'hC0, 8, 16'h0000, 99, r, oa, on); cs_hi;
    check("R1 bit7 set oe", {15'd0, on}, 16'd0);

    // R4: early select rise discards write
    cs_lo; frame(8'h20, 16, 16'hA000, 4, r, oa, on); cs_hi;
    check("R9 deselected oe", {15'd0, miso_oe}, 16'd0);
    rd(4, "R4 aborted", 0);

    // R10: 31 ones then a zero triggers nothing
    cs_lo; ones(31); bit_out(1'b0, g, o); cs_hi;
    check("R10 no trigger", {15'd0, busy}, 16'd0);
    rd(0, "R10 kept", 0);

    // R6/R7: long run of ones
    cs_lo; ones(40);
    check("R7 busy raised", {15'd0, busy}, 16'd1);
    cs_hi;
    cs_lo; frame(8'h28, 8, 16'h0077, 99, r, oa, on); cs_hi;
    check("R9 busy quiet", {15'd0, miso_oe}, 16'd0);
    wait_idle;
    check("R7 hold length", 16'(blast), 16'(HOLD));
    for (int i = 0; i < 8; i++) model[i] = por_of(i);
    rd(0, "R6 por 0", 0);
    rd(3, "R6 por 3", 0);
    rd(5, "R7 write in hold", 0);

    // R8: select tied low
    cs_lo;
    wr(4, 16'hBEEF, 1);
    rd(4, "R8 tied rd4", 1);
    rd(0, "R8 tied rd0", 1);
    wr(0, 16'h005B, 1);
    rd(0, "R8 tied rd0b", 1);
    ones(32);
    check("R6 tied trigger", {15'd0, busy}, 16'd1);
    wait_idle;
    for (int i = 0; i < 8; i++) model[i] = por_of(i);
    rd(4, "R8 resync", 1);
    rd(0, "R6 tied por", 1);
    cs_hi;

    clk_n(20);
    check("R8 queue drained", 16'(act_v.size()), 16'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule